// File: doc/BRIEF.md
# Flash completion status poller

This block sits on the host side of a parallel NOR flash and runs after software or another engine has issued a program or erase command. It reads the device's status word over a simple request/acknowledge bus until the operation has finished. It then reports the outcome. Two detection methods are available. In data polling, bit 7 of the status word is compared with bit 7 of the data that the location should hold. In toggle detection, bit 6 is compared across two back-to-back reads. Both methods watch bit 5, the device's "time limit exceeded" flag. When bit 5 is set, the poller re-reads before it declares a failure, because the status bit can settle in the same read in which bit 5 rises.

On a failure the poller issues one write of F0h, the flash reset command, so that the device returns to array reads. Only then does it raise its result flags. A poll-round limit can be set. It forces a failure, marked by a separate timeout flag, if the device never reaches a decision. For a program operation the status address must be the programmed location and the expected data the programmed value. For a chip erase it may be any unprotected location, with expected data FFh.

Top module: `nor_done_poller`

## Requirements
- R1: While reset is held, and after it is released, the outputs busy_o, bus_req_o, done_o, pass_o, fail_o and timeout_o are all 0.
- R2: With mode_i = 0 (data polling), the block reads at the status address. A read whose bit 7 equals bit 7 of the expected data ends the run with pass and no write, whatever bit 5 holds.
- R3: In data polling, a read whose bit 7 differs and whose bit 5 is 0 is followed by another read of the same address.
- R4: In data polling, a read whose bit 7 differs and whose bit 5 is 1 is followed by exactly one re-read. If bit 7 now matches the run passes; otherwise it fails.
- R5: With mode_i = 1 (toggle detection), reads come in pairs. If bit 6 is equal in both reads of a pair, the run passes with no write.
- R6: In toggle detection, a pair whose bit 6 differs and whose second read has bit 5 = 0 is followed by a new pair.
- R7: In toggle detection, a pair whose bit 6 differs and whose second read has bit 5 = 1 is followed by exactly one more pair. Equal bit 6 in that pair means pass; a difference means fail.
- R8: Every failing run ends with one write transfer to the status address whose low byte is F0h (upper bits 0) before done_o is raised with fail_o.
- R9: With poll_limit_i = L > 0, a run whose L-th round (one read in data polling, one pair in toggle detection) ends with "poll again" becomes a failure with timeout_o = 1, including the reset write. A decision reached within L rounds wins. L = 0 means no limit.
- R10: bus_req_o stays high with bus_we_o, bus_addr_o and bus_wdata_o unchanged until a clock edge where bus_ack_i is 1. Each such edge completes one transfer, and bus_req_o is 0 whenever busy_o is 0.
- R11: start_i is accepted only when the block is idle. A start while busy, and any change of mode, address, expected data or limit after acceptance, has no effect on the running poll.
- R12: busy_o rises in the cycle after an accepted start and falls with a one-cycle done_o pulse. Starting clears pass_o, fail_o and timeout_o; they then hold their result until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin polling (sampled while idle) |
| mode_i | input | 1 | 0 = data polling on bit 7, 1 = toggle detection on bit 6 |
| stat_addr_i | input | AW | Address to read status from |
| exp_data_i | input | DW | Data the location holds when done (bit 7 used) |
| poll_limit_i | input | CW | Maximum poll rounds, 0 = unlimited |
| bus_req_o | output | 1 | Transfer request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | AW | Transfer address |
| bus_wdata_o | output | DW | Write data (reset command) |
| bus_ack_i | input | 1 | Transfer acknowledge; read data valid |
| bus_rdata_i | input | DW | Status word returned by a read |
| busy_o | output | 1 | Poll in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Last run finished successfully |
| fail_o | output | 1 | Last run failed |
| timeout_o | output | 1 | Last failure was due to the round limit |

## Verification
The handshake properties assume that bus_ack_i is raised only while bus_req_o is high and that bus_rdata_i is valid in the same cycle. The bench's flash responder honours this. It acknowledges only a request it has observed, after a programmable gap of 0 to 2 cycles, and it always drops the acknowledge for at least one cycle afterwards. The status words are fed from a queue chosen per scenario. Every read therefore returns a defined byte, and the predicted number of reads never exceeds what the queue holds.

// File: rtl/nfp_pkg.sv
// Shared definitions for the flash completion status poller.
// Assumes status bits sit in the low byte of the data bus.
package nfp_pkg;
    typedef enum logic [2:0] {
        S_IDLE,     // waiting for a start
        S_DP_RD,    // data polling: normal read
        S_DP_CHK,   // data polling: re-read after limit flag
        S_TG_A,     // toggle: first read of a pair
        S_TG_B,     // toggle: second read of a pair
        S_TG_C,     // toggle: first read of the confirming pair
        S_TG_D,     // toggle: second read of the confirming pair
        S_RST_WR    // write the reset command
    } poll_state_t;

    localparam int unsigned POL_BIT  = 7;   // data-polarity status bit
    localparam int unsigned TGL_BIT  = 6;   // toggling status bit
    localparam int unsigned XCD_BIT  = 5;   // time-limit-exceeded bit
    localparam logic [7:0]  RST_CMD  = 8'hF0;
endpackage

// File: rtl/nfp_status_eval.sv
// Decodes one returned status word: polarity match against the expected
// data, toggle-bit equality against the previously captured bit, and the
// exceeded flag. Purely combinational; assumes DW >= 8.
module nfp_status_eval #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] rdata_i,
    input  logic [DW-1:0] exp_i,
    input  logic          prev_tgl_i,
    output logic          pol_match_o,
    output logic          tgl_same_o,
    output logic          exceeded_o
);
    import nfp_pkg::*;

    // Bits outside the status positions are intentionally not decoded.
    logic unused_bits;
    assign unused_bits = ^{rdata_i, exp_i};

    // Status comparisons.
    always_comb begin
        pol_match_o = (rdata_i[POL_BIT] == exp_i[POL_BIT]);
        tgl_same_o  = (rdata_i[TGL_BIT] == prev_tgl_i);
        exceeded_o  = rdata_i[XCD_BIT];
    end
endmodule

// File: rtl/nfp_round_limit.sv
// Counts completed poll rounds and flags when the current round is the
// last one allowed. The limit is loaded at start; zero disables the limit.
module nfp_round_limit #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] limit_i,
    input  logic          bump_i,
    output logic          expire_o
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim_q;

    // Round counter and captured limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= '0;
        end else if (load_i) begin
            cnt_q <= '0;
            lim_q <= limit_i;
        end else if (bump_i) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // Last permitted round is in progress.
    always_comb begin
        expire_o = (lim_q != '0) && (cnt_q == lim_q - CW'(1));
    end
endmodule

// File: rtl/nfp_bus_drive.sv
// Maps the poll state and latched address onto the request bus. Reads in
// every polling state, the reset-command write in the final fail state.
module nfp_bus_drive #(
    parameter int AW = 18,
    parameter int DW = 16
) (
    input  nfp_pkg::poll_state_t state_i,
    input  logic [AW-1:0]        addr_i,
    output logic                 req_o,
    output logic                 we_o,
    output logic [AW-1:0]        addr_o,
    output logic [DW-1:0]        wdata_o
);
    import nfp_pkg::*;

    // Request and direction follow the state.
    always_comb begin
        req_o  = (state_i != S_IDLE);
        we_o   = (state_i == S_RST_WR);
        addr_o = addr_i;
    end

    // Reset command placed in the low byte, zero-extended to the bus.
    generate
        if (DW == 8) begin : g_byte_bus
            assign wdata_o = RST_CMD;
        end else begin : g_wide_bus
            assign wdata_o = {{(DW-8){1'b0}}, RST_CMD};
        end
    endgenerate
endmodule

// File: rtl/nor_done_poller.sv
// Flash completion status poller. After a start it reads the status word
// repeatedly (data polling on bit 7 or toggle detection on bit 6), re-reads
// when the exceeded flag (bit 5) appears, writes the reset command on a
// failure and reports pass/fail/timeout. Assumes a bus slave that raises
// bus_ack_i only while bus_req_o is high, with read data valid alongside.
module nor_done_poller #(
    parameter int AW = 18,
    parameter int DW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          mode_i,
    input  logic [AW-1:0] stat_addr_i,
    input  logic [DW-1:0] exp_data_i,
    input  logic [CW-1:0] poll_limit_i,
    output logic          bus_req_o,
    output logic          bus_we_o,
    output logic [AW-1:0] bus_addr_o,
    output logic [DW-1:0] bus_wdata_o,
    input  logic          bus_ack_i,
    input  logic [DW-1:0] bus_rdata_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          pass_o,
    output logic          fail_o,
    output logic          timeout_o
);
    import nfp_pkg::*;

    poll_state_t   state_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] exp_q;
    logic          tgl_q;
    logic          tmo_q;
    logic          done_q, pass_q, fail_q, tout_q;

    logic pol_match, tgl_same, exceeded;
    logic accept, bump, expire;

    nfp_status_eval #(.DW(DW)) u_eval (
        .rdata_i     (bus_rdata_i),
        .exp_i       (exp_q),
        .prev_tgl_i  (tgl_q),
        .pol_match_o (pol_match),
        .tgl_same_o  (tgl_same),
        .exceeded_o  (exceeded)
    );

    nfp_round_limit #(.CW(CW)) u_limit (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (accept),
        .limit_i  (poll_limit_i),
        .bump_i   (bump),
        .expire_o (expire)
    );

    nfp_bus_drive #(.AW(AW), .DW(DW)) u_bus (
        .state_i (state_q),
        .addr_i  (addr_q),
        .req_o   (bus_req_o),
        .we_o    (bus_we_o),
        .addr_o  (bus_addr_o),
        .wdata_o (bus_wdata_o)
    );

    // Start acceptance and "poll another round" detection.
    always_comb begin
        accept = (state_q == S_IDLE) && start_i;
        bump   = bus_ack_i && !exceeded &&
                 (((state_q == S_DP_RD) && !pol_match) ||
                  ((state_q == S_TG_B)  && !tgl_same));
    end

    // Poll sequencer, operand capture and result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            addr_q  <= '0;
            exp_q   <= '0;
            tgl_q   <= 1'b0;
            tmo_q   <= 1'b0;
            done_q  <= 1'b0;
            pass_q  <= 1'b0;
            fail_q  <= 1'b0;
            tout_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (start_i) begin
                        addr_q  <= stat_addr_i;
                        exp_q   <= exp_data_i;
                        tmo_q   <= 1'b0;
                        pass_q  <= 1'b0;
                        fail_q  <= 1'b0;
                        tout_q  <= 1'b0;
                        state_q <= mode_i ? S_TG_A : S_DP_RD;
                    end
                end
                S_DP_RD: begin
                    if (bus_ack_i) begin
                        if (pol_match) begin
                            state_q <= S_IDLE;
                            done_q  <= 1'b1;
                            pass_q  <= 1'b1;
                        end else if (exceeded) begin
                            state_q <= S_DP_CHK;
                        end else if (expire) begin
                            tmo_q   <= 1'b1;
                            state_q <= S_RST_WR;
                        end
                    end
                end
                S_DP_CHK: begin
                    if (bus_ack_i) begin
                        if (pol_match) begin
                            state_q <= S_IDLE;
                            done_q  <= 1'b1;
                            pass_q  <= 1'b1;
                        end else begin
                            state_q <= S_RST_WR;
                        end
                    end
                end
                S_TG_A: begin
                    if (bus_ack_i) begin
                        tgl_q   <= bus_rdata_i[TGL_BIT];
                        state_q <= S_TG_B;
                    end
                end
                S_TG_B: begin
                    if (bus_ack_i) begin
                        if (tgl_same) begin
                            state_q <= S_IDLE;
                            done_q  <= 1'b1;
                            pass_q  <= 1'b1;
                        end else if (exceeded) begin
                            state_q <= S_TG_C;
                        end else if (expire) begin
                            tmo_q   <= 1'b1;
                            state_q <= S_RST_WR;
                        end else begin
                            state_q <= S_TG_A;
                        end
                    end
                end
                S_TG_C: begin
                    if (bus_ack_i) begin
                        tgl_q   <= bus_rdata_i[TGL_BIT];
                        state_q <= S_TG_D;
                    end
                end
                S_TG_D: begin
                    if (bus_ack_i) begin
                        if (tgl_same) begin
                            state_q <= S_IDLE;
                            done_q  <= 1'b1;
                            pass_q  <= 1'b1;
                        end else begin
                            state_q <= S_RST_WR;
                        end
                    end
                end
                S_RST_WR: begin
                    if (bus_ack_i) begin
                        state_q <= S_IDLE;
                        done_q  <= 1'b1;
                        fail_q  <= 1'b1;
                        tout_q  <= tmo_q;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Status outputs.
    always_comb begin
        busy_o    = (state_q != S_IDLE);
        done_o    = done_q;
        pass_o    = pass_q;
        fail_o    = fail_q;
        timeout_o = tout_q;
    end
endmodule

// File: rtl/nfp_poller_chk.sv
// Protocol and result checks for nor_done_poller, attached by bind.
// Assumes bus_ack_i is only raised while bus_req_o is high.
module nfp_poller_chk #(
    parameter int AW = 18,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          bus_ack_i,
    input logic          bus_req_o,
    input logic          bus_we_o,
    input logic [AW-1:0] bus_addr_o,
    input logic [DW-1:0] bus_wdata_o,
    input logic          busy_o,
    input logic          done_o,
    input logic          pass_o,
    input logic          fail_o,
    input logic          timeout_o
);
    // R10: request and its payload hold until acknowledged.
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_we_o) &&
                                    $stable(bus_addr_o) && $stable(bus_wdata_o));

    // R10: no request while idle.
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !bus_req_o);

    // R8: every write carries the reset command.
    p_reset_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o && bus_we_o |-> bus_wdata_o[7:0] == 8'hF0);

    // R12: done is a single-cycle pulse at idle with one result flag.
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_done_result_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o && ($countones({pass_o, fail_o}) == 1));

    // R9: a timeout is always reported as a failure.
    p_timeout_fail_r9: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> fail_o);

    // R11: a start while idle makes the block busy.
    p_start_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o |=> busy_o && !pass_o && !fail_o);
endmodule

bind nor_done_poller nfp_poller_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .bus_ack_i   (bus_ack_i),
    .bus_req_o   (bus_req_o),
    .bus_we_o    (bus_we_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .pass_o      (pass_o),
    .fail_o      (fail_o),
    .timeout_o   (timeout_o)
);

// File: tb/tb_nor_done_poller.sv
// Bench: a queue-fed flash responder plus a behavioural outcome predictor,
// compared against the bus and result ports on every clock.
module tb_nor_done_poller;
    localparam int AW = 18;
    localparam int DW = 16;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          mode_i = 1'b0;
    logic [AW-1:0] stat_addr_i = '0;
    logic [DW-1:0] exp_data_i = '0;
    logic [CW-1:0] poll_limit_i = '0;
    logic          bus_req_o, bus_we_o;
    logic [AW-1:0] bus_addr_o;
    logic [DW-1:0] bus_wdata_o;
    logic          bus_ack_i = 1'b0;
    logic [DW-1:0] bus_rdata_i = '0;
    logic          busy_o, done_o, pass_o, fail_o, timeout_o;

    always #4 clk = ~clk;

    nor_done_poller #(.AW(AW), .DW(DW), .CW(CW)) dut (.*);

    int n_tests = 0;
    int n_fail  = 0;

    logic [7:0]    sq[$];        // status bytes still to be returned
    int            ack_gap = 0;
    int            wcnt = 0;
    int            xi = 0;       // transfers seen in the current case
    int            exp_reads = 0;
    int            exp_out = 0;  // 0 pass, 1 fail, 2 timeout
    logic [AW-1:0] case_addr = '0;
    string         case_tag = "R1";
    bit            prev_req = 0, prev_ack = 0, prev_we = 0;
    logic [AW-1:0] prev_addr = '0;
    logic [DW-1:0] prev_wd = '0;

    task automatic check(bit ok, string tag, string what, longint act, longint expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    // Behavioural outcome from the requirements and the queued status bytes.
    task automatic predict(bit mode, logic [7:0] e, int lim);
        int i = 0;
        int rounds = 0;
        logic [7:0] a, b;
        exp_out = -1;
        while (exp_out < 0 && i < sq.size()) begin
            if (!mode) begin
                a = sq[i]; i++;
                if (a[7] == e[7]) exp_out = 0;
                else if (a[5]) begin
                    b = sq[i]; i++;
                    exp_out = (b[7] == e[7]) ? 0 : 1;
                end else begin
                    rounds++;
                    if (lim != 0 && rounds == lim) exp_out = 2;
                end
            end else begin
                a = sq[i]; b = sq[i+1]; i += 2;
                if (a[6] == b[6]) exp_out = 0;
                else if (b[5]) begin
                    a = sq[i]; b = sq[i+1]; i += 2;
                    exp_out = (a[6] == b[6]) ? 0 : 1;
                end else begin
                    rounds++;
                    if (lim != 0 && rounds == lim) exp_out = 2;
                end
            end
        end
        exp_reads = i;
    endtask

    // Per-clock comparison and flash responder.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!busy_o) check(!bus_req_o, "R10", "request while idle", bus_req_o, 0);
            if (prev_req && !prev_ack)
                check(bus_req_o && bus_we_o == prev_we && bus_addr_o == prev_addr &&
                      bus_wdata_o == prev_wd, "R10", "request held", bus_addr_o, prev_addr);
            if (busy_o) check(!pass_o && !fail_o && !timeout_o, "R12", "flags cleared while busy",
                              {pass_o, fail_o, timeout_o}, 0);
            if (bus_ack_i) begin
                bus_ack_i = 1'b0;
                wcnt = 0;
            end else if (bus_req_o) begin
                if (wcnt >= ack_gap) begin
                    if (xi < exp_reads)
                        check(!bus_we_o && bus_addr_o == case_addr, case_tag, "read transfer",
                              {bus_we_o, bus_addr_o}, {1'b0, case_addr});
                    else if (xi == exp_reads && exp_out != 0)
                        check(bus_we_o && bus_addr_o == case_addr && bus_wdata_o == 16'h00F0,
                              "R8", "reset write", bus_wdata_o, 16'h00F0);
                    else
                        check(1'b0, "R10", "unexpected transfer", xi, exp_reads);
                    if (!bus_we_o && sq.size() > 0) bus_rdata_i = {8'hA5, sq.pop_front()};
                    else bus_rdata_i = '0;
                    bus_ack_i = 1'b1;
                    xi++;
                end else begin
                    wcnt++;
                end
            end
            prev_req  = bus_req_o;
            prev_ack  = bus_ack_i;
            prev_we   = bus_we_o;
            prev_addr = bus_addr_o;
            prev_wd   = bus_wdata_o;
        end
    end

    task automatic run_case(string tag, bit mode, logic [AW-1:0] addr, logic [7:0] expb,
                            int lim, int gap, bit poke);
        int k = 0;
        logic ef, et;
        ack_gap = gap;
        predict(mode, expb, lim);
        xi = 0;
        case_addr = addr;
        case_tag = tag;
        @(negedge clk);
        start_i = 1'b1; mode_i = mode; stat_addr_i = addr;
        exp_data_i = {8'h3C, expb}; poll_limit_i = CW'(lim);
        @(negedge clk);
        start_i = 1'b0; mode_i = ~mode; stat_addr_i = ~addr;
        exp_data_i = ~exp_data_i; poll_limit_i = 16'd1;
        check(busy_o, "R12", "busy after start", busy_o, 1);
        if (poke) begin
            @(negedge clk);
            @(negedge clk);
            check(busy_o, "R11", "busy before second start", busy_o, 1);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (!done_o && k < 5000) begin
            @(negedge clk);
            k++;
        end
        ef = (exp_out != 0);
        et = (exp_out == 2);
        check(done_o, tag, "done pulse", done_o, 1);
        check(pass_o == !ef && fail_o == ef && timeout_o == et, tag, "result flags",
              {pass_o, fail_o, timeout_o}, {!ef, ef, et});
        check(xi == exp_reads + (ef ? 1 : 0), tag, "transfer count", xi, exp_reads + (ef ? 1 : 0));
        @(negedge clk);
        check(!done_o && !busy_o && pass_o == !ef && fail_o == ef && timeout_o == et,
              "R12", "pulse ends, flags held", {done_o, pass_o, fail_o, timeout_o},
              {1'b0, !ef, ef, et});
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy_o && !bus_req_o && !done_o && !pass_o && !fail_o && !timeout_o,
              "R1", "outputs in reset", {busy_o, bus_req_o, done_o, pass_o, fail_o, timeout_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !bus_req_o && !done_o && !pass_o && !fail_o && !timeout_o,
              "R1", "outputs after reset", {busy_o, bus_req_o, done_o, pass_o, fail_o, timeout_o}, 0);

        // R2: immediate match; match wins even with bit 5 set
        sq = '{8'h5A};                       run_case("R2", 0, 18'h01234, 8'h5A, 0, 0, 0);
        sq = '{8'hA0};                       run_case("R2", 0, 18'h00010, 8'h80, 0, 1, 0);
        // R3: several mismatches with bit 5 clear, then erase complete
        sq = '{8'h00, 8'h00, 8'h00, 8'hFF};  run_case("R3", 0, 18'h3FFFF, 8'hFF, 0, 1, 0);
        // R4: re-read after bit 5 passes / fails
        sq = '{8'h00, 8'h20, 8'h80};         run_case("R4", 0, 18'h00400, 8'hFF, 0, 0, 0);
        sq = '{8'h20, 8'h20};                run_case("R4", 0, 18'h00401, 8'hFF, 0, 2, 0);
        // R5: toggle stopped at once
        sq = '{8'h40, 8'h40};                run_case("R5", 1, 18'h12345, 8'h00, 0, 2, 0);
        // R6 + R11: toggling pairs, second start ignored
        sq = '{8'h00, 8'h40, 8'h40, 8'h00, 8'h00, 8'h00};
        run_case("R6", 1, 18'h00777, 8'h00, 0, 2, 1);
        // R7: confirming pair passes / fails
        sq = '{8'h00, 8'h40, 8'h00, 8'h60, 8'h20, 8'h20};
        run_case("R7", 1, 18'h00100, 8'h00, 0, 1, 0);
        sq = '{8'h40, 8'h20, 8'h00, 8'h40};  run_case("R7", 1, 18'h00101, 8'h00, 0, 0, 0);
        // R9: timeouts, decision on last allowed round, unlimited
        sq = '{8'h00, 8'h00, 8'h00};         run_case("R9", 0, 18'h00200, 8'hFF, 3, 1, 0);
        sq = '{8'h00, 8'h40, 8'h00, 8'h40};  run_case("R9", 1, 18'h00201, 8'h00, 2, 0, 0);
        sq = '{8'h00, 8'h00, 8'h80};         run_case("R9", 0, 18'h00202, 8'h80, 3, 0, 0);
        sq = {};
        for (int j = 0; j < 20; j++) sq.push_back(8'h00);
        sq.push_back(8'h80);
        run_case("R9", 0, 18'h00203, 8'h80, 0, 0, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule